// File: doc/BRIEF.md
# Lowest-Priority Interrupt Router

The router takes interrupt messages from one input and hands each of them to one or more of a set of processor targets. Every target reports its current task priority, a small unsigned number where a lower value means the processor is doing less important work and can be interrupted more cheaply. Each message carries a routing mode, a destination mask and an 8-bit vector. The router picks the addressed targets in the cycle it accepts the message. It then raises a deliver strobe toward each chosen target together with the vector, and holds the strobe until that target takes it.

Three routing modes are supported. A broadcast goes to every target. A fixed message goes to exactly the targets named in its mask. A lowest-priority message goes to a single target: the one in the mask with the smallest task priority. When several targets share that minimum, a rotating pointer spreads the work among them. A message that could reach nobody is consumed and flagged. Inter-processor vectors are carried like any other vector.

Top module: `irq_lp_router`

## Requirements
- R1: After reset, msg_ready is 1, dlv_valid is all zero, err_drop is 0, and the rotation pointer selects target 0.
- R2: A message with msg_mode = 1 (broadcast) is delivered to all targets whatever msg_dest holds.
- R3: A message with msg_mode = 0 (fixed) is delivered to exactly the targets whose msg_dest bit is set, where bit i names target i.
- R4: A message with msg_mode = 2 (lowest) is delivered to exactly one target. That target has its msg_dest bit set and holds the smallest value among those targets, where target i's priority is tgt_prio[4i+3:4i] as sampled in the accept cycle.
- R5: Among lowest-priority candidates with equal priority, the winner is the first one found when scanning upward from the rotation pointer and wrapping from target 3 to target 0. After each lowest-priority delivery the pointer becomes the winner plus one, modulo 4. Fixed messages, broadcasts and dropped messages leave the pointer unchanged.
- R6: A fixed or lowest message with an all-zero msg_dest, and any message with msg_mode = 3, is consumed and delivered to nobody. In that case err_drop is 1 for exactly the one cycle after acceptance.
- R7: A message is accepted in a cycle where msg_valid and msg_ready are both 1. Its deliver strobes appear in the next cycle. msg_ready stays 0 while any strobe is pending, so a waiting message is neither taken nor allowed to move the pointer.
- R8: Each dlv_valid bit stays high until the same bit of dlv_ready is 1 in that cycle, and targets may accept in different cycles. dlv_vector is stable while any strobe is high.
- R9: The vector reaches dlv_vector unchanged for every 8-bit value, including the inter-processor range 251 to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Message offered |
| msg_ready | output | 1 | Router can take a message |
| msg_mode | input | 2 | 0 fixed, 1 broadcast, 2 lowest, 3 reserved |
| msg_dest | input | 4 | Destination / candidate mask, bit i = target i |
| msg_vector | input | 8 | Interrupt vector |
| tgt_prio | input | 16 | Task priority of each target, 4 bits per target |
| dlv_valid | output | 4 | Per-target deliver strobe |
| dlv_ready | input | 4 | Per-target accept |
| dlv_vector | output | 8 | Vector of the message being delivered |
| err_drop | output | 1 | One-cycle pulse for a dropped message |

## Verification
Two functions meet in the same cycle when a broadcast is only partly accepted while a lowest-priority message is already waiting at the input. Holding up the stall of the delivery must keep msg_ready low and the rotation pointer where it was. The bench provokes this by letting two targets accept, then the other two, while msg_valid stays high. It then checks that the waiting message goes to the target the unmoved pointer names, and that a second identical message goes to the next one. Tie-breaking and mask restriction are also combined in one arbitration: lower-priority targets left out of the mask must never win.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    typedef enum logic [1:0] {
        MODE_FIXED  = 2'd0,
        MODE_BCAST  = 2'd1,
        MODE_LOWEST = 2'd2,
        MODE_RSVD   = 2'd3
    } route_mode_e;

    localparam int unsigned DEF_TARGETS = 4;
    localparam int unsigned DEF_PRIO_W  = 4;
    localparam int unsigned DEF_VEC_W   = 8;

    // Index width that stays legal for a single target.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irq_lp_select.sv
module irq_lp_select #(
    parameter int unsigned N  = irq_route_pkg::DEF_TARGETS,
    parameter int unsigned PW = irq_route_pkg::DEF_PRIO_W,
    localparam int unsigned IW = irq_route_pkg::idx_width(N)
) (
    input  logic [N*PW-1:0] prio,
    input  logic [N-1:0]    cand,
    input  logic [IW-1:0]   ptr,
    output logic [N-1:0]    win_oh,
    output logic [IW-1:0]   win_idx,
    output logic            found
);

    logic [PW-1:0] pv [N];
    logic [PW-1:0] min_v;
    logic [N-1:0]  tie;

    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign pv[g]  = prio[g*PW +: PW];
        assign tie[g] = cand[g] && (pv[g] == min_v);
    end

    // Smallest priority among the candidates.
    always_comb begin
        min_v = '1;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (pv[i] < min_v)) begin
                min_v = pv[i];
            end
        end
    end

    // Cyclic scan from the pointer over the tied candidates.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (int'(ptr) + k) % N;
            if (!found && tie[j]) begin
                found   = 1'b1;
                win_idx = IW'(j);
            end
        end
    end

    always_comb begin
        win_oh = '0;
        if (found) begin
            win_oh[win_idx] = 1'b1;
        end
    end

endmodule

// File: rtl/irq_rr_rotor.sv
module irq_rr_rotor #(
    parameter int unsigned N = irq_route_pkg::DEF_TARGETS,
    localparam int unsigned IW = irq_route_pkg::idx_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic [IW-1:0] win_idx,
    output logic [IW-1:0] ptr
);

    localparam logic [IW-1:0] LAST = IW'(N - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (win_idx == LAST) ? '0 : win_idx + 1'b1;
        end
    end

endmodule

// File: rtl/irq_dlv_tracker.sv
module irq_dlv_tracker #(
    parameter int unsigned N     = irq_route_pkg::DEF_TARGETS,
    parameter int unsigned VEC_W = irq_route_pkg::DEF_VEC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [N-1:0]     load_mask,
    input  logic [VEC_W-1:0] load_vec,
    input  logic [N-1:0]     take,
    output logic [N-1:0]     pend,
    output logic [VEC_W-1:0] vec_q,
    output logic             busy
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            vec_q <= '0;
        end else if (load) begin
            pend  <= load_mask;
            vec_q <= load_vec;
        end else begin
            pend  <= pend & ~take;
        end
    end

    assign busy = |pend;

endmodule

// File: rtl/irq_lp_router.sv
module irq_lp_router
    import irq_route_pkg::*;
#(
    parameter int unsigned N_TGT  = DEF_TARGETS,
    parameter int unsigned PRIO_W = DEF_PRIO_W,
    parameter int unsigned VEC_W  = DEF_VEC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    msg_valid,
    output logic                    msg_ready,
    input  logic [1:0]              msg_mode,
    input  logic [N_TGT-1:0]        msg_dest,
    input  logic [VEC_W-1:0]        msg_vector,
    input  logic [N_TGT*PRIO_W-1:0] tgt_prio,
    output logic [N_TGT-1:0]        dlv_valid,
    input  logic [N_TGT-1:0]        dlv_ready,
    output logic [VEC_W-1:0]        dlv_vector,
    output logic                    err_drop
);

    localparam int unsigned IW = idx_width(N_TGT);

    route_mode_e      mode;
    logic             accept;
    logic             busy;
    logic [N_TGT-1:0] route;
    logic [N_TGT-1:0] lp_oh;
    logic [IW-1:0]    lp_idx;
    logic             lp_found;
    logic [IW-1:0]    ptr;
    logic             drop;
    logic             lp_adv;

    assign mode      = route_mode_e'(msg_mode);
    assign msg_ready = ~busy;
    assign accept    = msg_valid & msg_ready;

    irq_lp_select #(.N(N_TGT), .PW(PRIO_W)) u_select (
        .prio    (tgt_prio),
        .cand    (msg_dest),
        .ptr     (ptr),
        .win_oh  (lp_oh),
        .win_idx (lp_idx),
        .found   (lp_found)
    );

    always_comb begin
        unique case (mode)
            MODE_BCAST:  route = '1;
            MODE_FIXED:  route = msg_dest;
            MODE_LOWEST: route = lp_oh;
            default:     route = '0;
        endcase
    end

    assign drop   = (route == '0);
    assign lp_adv = accept && (mode == MODE_LOWEST) && lp_found;

    irq_rr_rotor #(.N(N_TGT)) u_rotor (
        .clk     (clk),
        .rst     (rst),
        .adv     (lp_adv),
        .win_idx (lp_idx),
        .ptr     (ptr)
    );

    irq_dlv_tracker #(.N(N_TGT), .VEC_W(VEC_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .load      (accept && !drop),
        .load_mask (route),
        .load_vec  (msg_vector),
        .take      (dlv_ready),
        .pend      (dlv_valid),
        .vec_q     (dlv_vector),
        .busy      (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_drop <= 1'b0;
        end else begin
            err_drop <= accept && drop;
        end
    end

endmodule

// File: rtl/irq_lp_router_chk.sv
module irq_lp_router_chk #(
    parameter int unsigned N_TGT  = 4,
    parameter int unsigned PRIO_W = 4,
    parameter int unsigned VEC_W  = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    msg_valid,
    input logic                    msg_ready,
    input logic [1:0]              msg_mode,
    input logic [N_TGT-1:0]        msg_dest,
    input logic [VEC_W-1:0]        msg_vector,
    input logic [N_TGT*PRIO_W-1:0] tgt_prio,
    input logic [N_TGT-1:0]        dlv_valid,
    input logic [N_TGT-1:0]        dlv_ready,
    input logic [VEC_W-1:0]        dlv_vector,
    input logic                    err_drop
);

    logic                    acc;
    logic                    acc_drop;
    logic [PRIO_W-1:0]       cur_min;
    logic                    lp_q;
    logic [PRIO_W-1:0]       min_q;
    logic [N_TGT*PRIO_W-1:0] prio_q;
    logic [N_TGT-1:0]        dest_q;
    logic [PRIO_W-1:0]       got_prio;

    assign acc      = msg_valid && msg_ready;
    assign acc_drop = (msg_mode == 2'd3) || ((msg_mode != 2'd1) && (msg_dest == '0));

    always_comb begin
        cur_min = '1;
        for (int i = 0; i < N_TGT; i++) begin
            if (msg_dest[i] && (tgt_prio[i*PRIO_W +: PRIO_W] < cur_min)) begin
                cur_min = tgt_prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

    always_comb begin
        got_prio = '1;
        for (int i = 0; i < N_TGT; i++) begin
            if (dlv_valid[i]) begin
                got_prio = prio_q[i*PRIO_W +: PRIO_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lp_q   <= 1'b0;
            min_q  <= '0;
            prio_q <= '0;
            dest_q <= '0;
        end else begin
            lp_q   <= acc && (msg_mode == 2'd2) && (msg_dest != '0);
            min_q  <= cur_min;
            prio_q <= tgt_prio;
            dest_q <= msg_dest;
        end
    end

    // R8
    hold_until_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (|dlv_valid) |=> (dlv_valid == $past(dlv_valid & ~dlv_ready)));

    // R8
    vector_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (|dlv_valid) |=> (!(|dlv_valid) || $stable(dlv_vector)));

    // R2
    bcast_all_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && (msg_mode == 2'd1)) |=> (dlv_valid == '1));

    // R4
    lowest_min_chk: assert property (@(posedge clk) disable iff (rst)
        lp_q |-> (($countones(dlv_valid) == 1) && ((dlv_valid & ~dest_q) == '0)
                  && (got_prio == min_q)));

    // R6
    drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && acc_drop) |=> (err_drop && (dlv_valid == '0)));

    // R6
    flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
        err_drop |-> $past(acc && acc_drop));

    // R9
    vector_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !acc_drop) |=> (dlv_vector == $past(msg_vector)));

    // R7
    no_take_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (|dlv_valid && |(dlv_valid & ~dlv_ready)) |=> !msg_ready);

endmodule

bind irq_lp_router irq_lp_router_chk #(
    .N_TGT(N_TGT), .PRIO_W(PRIO_W), .VEC_W(VEC_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_mode   (msg_mode),
    .msg_dest   (msg_dest),
    .msg_vector (msg_vector),
    .tgt_prio   (tgt_prio),
    .dlv_valid  (dlv_valid),
    .dlv_ready  (dlv_ready),
    .dlv_vector (dlv_vector),
    .err_drop   (err_drop)
);

// File: tb/irq_lp_router_bench.sv
module irq_lp_router_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic [1:0]  mode;
        logic [3:0]  dest;
        logic [15:0] prio;
        logic [7:0]  vec;
        logic [3:0]  exp_mask;
        logic        exp_err;
    } vec_t;

    // Rotation pointer flow: 0,1,2,0,1,1,1,1,2,2,2,2,3,0,0 -> 1
    localparam vec_t TBL [15] = '{
        '{2'd2, 4'hF, 16'h5555, 8'h20, 4'h1, 1'b0}, // R5 tie, ptr 0
        '{2'd2, 4'hF, 16'h5555, 8'h21, 4'h2, 1'b0}, // R5 ptr moved to 1
        '{2'd2, 4'hF, 16'h3973, 8'h30, 4'h8, 1'b0}, // R4 R5 min 3 at 0,3; ptr 2
        '{2'd2, 4'hF, 16'h3973, 8'h31, 4'h1, 1'b0}, // R5 wrap to 0
        '{2'd1, 4'h0, 16'h0000, 8'hFB, 4'hF, 1'b0}, // R2 R9 broadcast, mask empty
        '{2'd0, 4'h4, 16'h0000, 8'h40, 4'h4, 1'b0}, // R3
        '{2'd0, 4'hA, 16'h0000, 8'h41, 4'hA, 1'b0}, // R3
        '{2'd2, 4'h6, 16'h0220, 8'h50, 4'h2, 1'b0}, // R4 mask excludes lower
        '{2'd2, 4'h0, 16'h0000, 8'h51, 4'h0, 1'b1}, // R6 empty lowest
        '{2'd0, 4'h0, 16'h0000, 8'h52, 4'h0, 1'b1}, // R6 empty fixed
        '{2'd3, 4'hF, 16'h0000, 8'h53, 4'h0, 1'b1}, // R6 reserved mode
        '{2'd2, 4'hF, 16'hF000, 8'hFF, 4'h4, 1'b0}, // R5 ptr still 2, R9
        '{2'd2, 4'h9, 16'h1111, 8'h60, 4'h8, 1'b0}, // R5 ptr 3
        '{2'd2, 4'hF, 16'h0FFF, 8'h61, 4'h8, 1'b0}, // R4 unique min at 3
        '{2'd2, 4'hF, 16'h5555, 8'h62, 4'h1, 1'b0}  // R5 ptr wrapped to 0
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        msg_valid = 1'b0;
    logic        msg_ready;
    logic [1:0]  msg_mode = 2'd0;
    logic [3:0]  msg_dest = 4'h0;
    logic [7:0]  msg_vector = 8'h00;
    logic [15:0] tgt_prio = 16'h0000;
    logic [3:0]  dlv_valid;
    logic [3:0]  dlv_ready = 4'hF;
    logic [7:0]  dlv_vector;
    logic        err_drop;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_lp_router u_irq_lp_router (
        .clk        (clk),
        .rst        (rst),
        .msg_valid  (msg_valid),
        .msg_ready  (msg_ready),
        .msg_mode   (msg_mode),
        .msg_dest   (msg_dest),
        .msg_vector (msg_vector),
        .tgt_prio   (tgt_prio),
        .dlv_valid  (dlv_valid),
        .dlv_ready  (dlv_ready),
        .dlv_vector (dlv_vector),
        .err_drop   (err_drop)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic [3:0] d,
                         input logic [15:0] p, input logic [7:0] v);
        msg_valid  = 1'b1;
        msg_mode   = m;
        msg_dest   = d;
        tgt_prio   = p;
        msg_vector = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", 32'(msg_ready), 32'd1);
        check("R1 dlv_valid", 32'(dlv_valid), 32'd0);
        check("R1 err_drop", 32'(err_drop), 32'd0);

        for (int i = 0; i < 15; i++) begin
            drive(TBL[i].mode, TBL[i].dest, TBL[i].prio, TBL[i].vec);
            check("R7 ready idle", 32'(msg_ready), 32'd1);
            check("R6 pulse ends", 32'(err_drop), 32'd0);
            @(negedge clk);
            msg_valid = 1'b0;
            check("R2 R3 R4 R5 route", 32'(dlv_valid), 32'(TBL[i].exp_mask));
            check("R6 err", 32'(err_drop), 32'(TBL[i].exp_err));
            if (!TBL[i].exp_err) begin
                check("R9 vector", 32'(dlv_vector), 32'(TBL[i].vec));
            end
            @(negedge clk);
        end
        // pointer is now 1

        // R8 partial acceptance with a message waiting (R7)
        dlv_ready = 4'h3;
        drive(2'd1, 4'h0, 16'h5555, 8'h77);
        @(negedge clk);
        check("R2 bcast", 32'(dlv_valid), 32'hF);
        check("R7 busy", 32'(msg_ready), 32'd0);
        drive(2'd2, 4'hF, 16'h5555, 8'h88);
        @(negedge clk);
        check("R8 partial", 32'(dlv_valid), 32'hC);
        check("R8 vec held", 32'(dlv_vector), 32'h77);
        check("R7 still busy", 32'(msg_ready), 32'd0);
        dlv_ready = 4'hC;
        @(negedge clk);
        check("R8 drained", 32'(dlv_valid), 32'h0);
        check("R7 ready again", 32'(msg_ready), 32'd1);
        dlv_ready = 4'hF;
        @(negedge clk);
        check("R5 ptr held while waiting", 32'(dlv_valid), 32'h2);
        check("R9 waiting vec", 32'(dlv_vector), 32'h88);
        @(negedge clk);
        @(negedge clk);
        check("R5 ptr one step", 32'(dlv_valid), 32'h4);
        msg_valid = 1'b0;
        @(negedge clk);

        // R1 pointer back to 0 after reset
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 after reset", 32'(dlv_valid), 32'd0);
        drive(2'd2, 4'hF, 16'h5555, 8'h99);
        @(negedge clk);
        msg_valid = 1'b0;
        check("R1 ptr zero", 32'(dlv_valid), 32'h1);
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule